// File: doc/BRIEF.md
# Partitioned Recency Stack for a Shared Cache Set

This block holds the replacement state of a single set in a last-level cache that several cores share. It keeps an ordered stack of the set's ways, from least to most recently favoured, and notes for every way which core placed its current block there. The surrounding cache controller looks up the tags itself and then reports each access to this block: whether it hit, which way hit, and which core asked. On a miss the controller fills the way that the block names as victim.

Capacity is shared out softly rather than fenced off. Each core has an allocation count, loaded from outside and free to change at any time. A core's new block enters the stack that many places above the bottom, so a core with a small allocation loses its blocks quickly and one with a large allocation keeps them longer. A hit moves a block up by a single place, and only when a free-running pseudo-random value falls below a programmable threshold. This lets a re-used block climb slowly instead of jumping to the top. An allocation of one gives dead-on-arrival insertion.

Top module: `partition_recency_stack`

## Requirements
- R1: After reset the stack holds way k at k places below the top, so way 0 is most favoured and the victim is way WAYS-1. Every way's owner is core 0.
- R2: `victim_o` always names the way at the bottom of the stack. A miss refills that way.
- R3: On a miss from core c with clamped allocation a, the refilled way is placed at position a counted from the bottom, where position 1 is the bottom. The entries at positions 2..a each move down one place, and the entries above position a keep their places.
- R4: With an allocation of 1, the refilled way stays at the bottom. If no further access touches it, the next miss evicts it again.
- R5: The allocation field of a core is AW bits wide at bit offset core*AW of `alloc_i`. A field value of 0 acts as 1, and a value above WAYS acts as WAYS (insertion at the top).
- R6: When `prom_thresh_i` is 65536, every hit promotes: the hit way swaps places with the entry one step above it. A hit on the top entry changes nothing.
- R7: When `prom_thresh_i` is 0, a hit never changes the stack. An intermediate threshold t promotes when the current 16-bit pseudo-random value is below t.
- R8: A miss records the requesting core as owner of the refilled way, and a hit leaves owners unchanged. `victim_owner_o` shows the owner of the current victim way.
- R9: The stack and owners change on the clock edge at which `acc_i` is sampled high and at no other edge. The outputs are combinational from the stored state.
- R10: The allocation is read at the edge of each miss, so a changed allocation takes effect on the very next miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| acc_i | input | 1 | Access strobe, one per access |
| hit_i | input | 1 | Access hit in the set |
| hit_way_i | input | WW | Way that hit |
| core_i | input | CW | Requesting core |
| alloc_i | input | CORES*AW | Per-core allocation fields |
| prom_thresh_i | input | 17 | Promotion threshold; 0 never, 65536 always |
| victim_o | output | WW | Way to refill on a miss |
| victim_owner_o | output | CW | Core owning the victim way |

## Verification
Only the bottom of the stack is visible at the ports, so a fault in the middle of the stack stays hidden until misses drain entries down to the victim position. The bench therefore keeps a behavioural model of the full order and compares the victim and its owner on every cycle. A wrong shift or a wrong insertion point then appears within as many misses as the faulty entry sits above the bottom. A wrong owner appears as soon as that way becomes the victim. A stray promotion or a dead-on-arrival failure shows up on the cycle after the access.

// File: rtl/partition_recency_stack.sv
module partition_recency_stack #(
  parameter int WAYS  = 16,
  parameter int CORES = 4,
  parameter logic [15:0] TAPS = 16'hB400,
  localparam int WW = $clog2(WAYS),
  localparam int CW = $clog2(CORES),
  localparam int AW = $clog2(WAYS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                acc_i,
  input  logic                hit_i,
  input  logic [WW-1:0]       hit_way_i,
  input  logic [CW-1:0]       core_i,
  input  logic [CORES*AW-1:0] alloc_i,
  input  logic [16:0]         prom_thresh_i,
  output logic [WW-1:0]       victim_o,
  output logic [CW-1:0]       victim_owner_o
);

  logic [WW-1:0] stk_q [WAYS];
  logic [WW-1:0] stk_d [WAYS];
  logic [CW-1:0] own_q [WAYS];
  logic [15:0]   rng_q;

  logic [AW-1:0] raw_alloc;
  logic [WW-1:0] ins_idx;
  logic [WW-1:0] hit_pos;
  logic          promote;

  assign raw_alloc = alloc_i[core_i*AW +: AW];
  assign ins_idx   = (raw_alloc == '0)                ? '0 :
                     (raw_alloc > AW'(WAYS))          ? WW'(WAYS - 1) :
                                                        WW'(raw_alloc - 1'b1);
  assign promote   = {1'b0, rng_q} < prom_thresh_i;
  assign victim_o       = stk_q[0];
  assign victim_owner_o = own_q[stk_q[0]];

  always_comb begin
    hit_pos = '0;
    for (int p = 0; p < WAYS; p++)
      if (stk_q[p] == hit_way_i) hit_pos = WW'(p);
  end

  always_comb begin
    for (int p = 0; p < WAYS; p++) stk_d[p] = stk_q[p];
    if (!hit_i) begin
      for (int p = 0; p < WAYS - 1; p++)
        if (WW'(p) < ins_idx) stk_d[p] = stk_q[p+1];
      stk_d[ins_idx] = stk_q[0];
    end else if (promote && hit_pos != WW'(WAYS - 1)) begin
      stk_d[hit_pos]        = stk_q[hit_pos + 1'b1];
      stk_d[hit_pos + 1'b1] = stk_q[hit_pos];
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) rng_q <= 16'hACE1;
    else         rng_q <= {1'b0, rng_q[15:1]} ^ (rng_q[0] ? TAPS : 16'h0);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int p = 0; p < WAYS; p++) begin
        stk_q[p] <= WW'(WAYS - 1 - p);
        own_q[p] <= '0;
      end
    end else if (acc_i) begin
      for (int p = 0; p < WAYS; p++) stk_q[p] <= stk_d[p];
      if (!hit_i) own_q[stk_q[0]] <= core_i;
    end
  end

endmodule

module partition_recency_stack_chk #(
  parameter int WAYS  = 16,
  parameter int CORES = 4,
  localparam int WW = $clog2(WAYS),
  localparam int CW = $clog2(CORES),
  localparam int AW = $clog2(WAYS + 1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                acc_i,
  input logic                hit_i,
  input logic [WW-1:0]       hit_way_i,
  input logic [CW-1:0]       core_i,
  input logic [CORES*AW-1:0] alloc_i,
  input logic [16:0]         prom_thresh_i,
  input logic [WW-1:0]       victim_o,
  input logic [CW-1:0]       victim_owner_o
);
  logic [AW-1:0] req_alloc;
  logic          low_alloc;
  assign req_alloc = alloc_i[core_i*AW +: AW];
  assign low_alloc = (req_alloc <= AW'(1));

  a_r9_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> $stable(victim_o) && $stable(victim_owner_o));

  a_r4_dead_on_arrival: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && !hit_i && low_alloc |=> victim_o == $past(victim_o));

  a_r2_miss_moves_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && !hit_i && !low_alloc |=> victim_o != $past(victim_o));

  a_r8_owner_recorded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && !hit_i && low_alloc |=> victim_owner_o == $past(core_i));

  a_r7_no_promotion: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && hit_i && prom_thresh_i == 17'd0 |=> $stable(victim_o));

  a_r6_bottom_promoted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && hit_i && prom_thresh_i[16] && hit_way_i == victim_o
    |=> victim_o != $past(victim_o));
endmodule

bind partition_recency_stack partition_recency_stack_chk #(.WAYS(WAYS), .CORES(CORES)) u_chk (.*);

// File: tb/partition_recency_stack_tb.sv
module partition_recency_stack_tb;
  localparam int WAYS = 16, CORES = 4, WW = 4, CW = 2, AW = 5;

  logic clk = 0, rst_n = 0, acc = 0, hit = 0;
  logic [WW-1:0] hway = '0;
  logic [CW-1:0] core = '0;
  logic [CORES*AW-1:0] alloc = '0;
  logic [16:0] thresh = 17'd65536;
  logic [WW-1:0] victim;
  logic [CW-1:0] vowner;

  int checks = 0, errors = 0;
  int mstk [WAYS];
  int mown [WAYS];

  always #2 clk = ~clk;

  partition_recency_stack #(.WAYS(WAYS), .CORES(CORES)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .hit_i(hit), .hit_way_i(hway),
    .core_i(core), .alloc_i(alloc), .prom_thresh_i(thresh),
    .victim_o(victim), .victim_owner_o(vowner));

  function automatic int clamp(int a);
    if (a < 1) return 1;
    if (a > WAYS) return WAYS;
    return a;
  endfunction

  task automatic set_alloc(int c, int a);
    alloc[c*AW +: AW] = AW'(a);
  endtask

  task automatic model_update(bit h, int w, int c);
    if (!h) begin
      int a = clamp(int'(alloc[c*AW +: AW]));
      int v = mstk[0];
      for (int p = 0; p < a - 1; p++) mstk[p] = mstk[p+1];
      mstk[a-1] = v;
      mown[v] = c;
    end else if (thresh == 17'd65536) begin
      for (int p = 0; p < WAYS - 1; p++)
        if (mstk[p] == w) begin
          mstk[p] = mstk[p+1];
          mstk[p+1] = w;
          break;
        end
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (int'(victim) != mstk[0] || int'(vowner) != mown[mstk[0]]) begin
      errors++;
      $display("FAIL %s: victim=%0d owner=%0d expected victim=%0d owner=%0d",
               tag, victim, vowner, mstk[0], mown[mstk[0]]);
    end
  endtask

  task automatic access(bit h, int w, int c, string tag);
    @(negedge clk);
    acc = 1; hit = h; hway = WW'(w); core = CW'(c);
    @(posedge clk);
    model_update(h, w, c);
    #1 acc = 0;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare(tag);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < WAYS; p++) begin mstk[p] = WAYS - 1 - p; mown[p] = 0; end
    set_alloc(0, 8); set_alloc(1, 4); set_alloc(2, 1); set_alloc(3, 3);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    compare("R1 R8 reset order");
    checks++;
    if (victim != 4'd15) begin
      errors++; $display("FAIL R1: victim=%0d expected 15", victim);
    end

    access(0, 0, 0, "R2 R3 R8 miss core0");
    access(0, 0, 1, "R2 R3 R8 miss core1");
    access(0, 0, 3, "R3 miss core3");
    idle(4, "R9 idle");

    access(0, 0, 2, "R4 dead on arrival");
    checks++;
    if (vowner != 2'd2) begin
      errors++; $display("FAIL R8: owner=%0d expected 2", vowner);
    end
    access(0, 0, 2, "R4 repeat");
    access(0, 0, 2, "R4 repeat");

    set_alloc(3, 0);
    access(0, 0, 3, "R5 zero acts as one");
    set_alloc(3, 25);
    access(0, 0, 3, "R5 above ways acts as top");
    access(0, 0, 3, "R5 above ways again");

    set_alloc(1, 12);
    access(0, 0, 1, "R10 new allocation");
    set_alloc(1, 2);
    access(0, 0, 1, "R10 changed again");

    thresh = 17'd65536;
    access(1, mstk[0], 0, "R6 promote bottom");
    access(1, mstk[WAYS-1], 1, "R6 top unchanged");
    access(1, mstk[7], 2, "R6 promote middle");
    thresh = 17'd0;
    access(1, mstk[0], 0, "R7 never promote");
    access(1, mstk[3], 3, "R7 never promote");

    for (int i = 0; i < 3000; i++) begin
      if (i % 100 == 0)
        for (int c = 0; c < CORES; c++) set_alloc(c, $urandom_range(0, 20));
      thresh = ((i / 500) % 2 == 0) ? 17'd65536 : 17'd0;
      if ($urandom_range(0, 2) == 0)
        idle(1, "R9 random idle");
      else
        access($urandom_range(0, 1), $urandom_range(0, WAYS - 1),
               $urandom_range(0, CORES - 1), "R2 R3 R6 R7 R8 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule